// File: doc/BRIEF.md
# Windowed Register Operand Address Generator

This block turns the three register operand fields of an instruction into physical register-file addresses and returns the two source operands. The fields are source A, source B and destination C. Each field has its own narrow adder and its own source selector. A field can name a register in a stack-relative local window, a register in a flat global bank, or the register held in a per-port indirect pointer. The block also holds the register file. The file has two read ports and one write port, and the write is retired one stage after the read.

In use, an issue stage presents the operand fields together with a write-enable and the result data to be stored in the destination. Two clock edges later the two operands appear with a valid strobe. A loadable window pointer moves the local window. Three pointer registers supply addresses for fields that are zero. Decode, the ALU, window spill and fill, and memory all sit outside this block.

The physical address is one bank bit followed by a seven-bit index: bank 1 is the local bank and bank 0 is the global bank.

Top module: `regwin_operand_unit`

## Requirements
- R1: After reset the operand valid strobe and both operand outputs are 0, the window pointer is 0 and all three indirect pointers hold physical address 0.
- R2: A field whose bit 7 is 1 selects local entry (field[6:0] + window pointer) modulo 128, which is physical address {1, sum}.
- R3: A nonzero field whose bit 7 is 0 selects global entry field[6:0], which is physical address {0, field[6:0]}, with no pointer offset.
- R4: A field equal to zero takes its full 8-bit physical address from the indirect pointer of its own port. Bit 7 of that address picks the bank, and no window offset is applied.
- R5: An issue sampled on one rising edge delivers both operands with the valid strobe asserted after the next rising edge. A cycle without issue produces no valid strobe.
- R6: With write-enable set, the write data is stored at the destination address of that same instruction. That instruction's own reads return the values from before the write.
- R7: Every instruction issued after a writer, including the very next one, reads the written value (write-to-read bypass).
- R8: A window-pointer load changes addressing only for instructions issued in later cycles. An issue in the same cycle as the load uses the old value.
- R9: Pointer write-enable bit 0 loads the source-A pointer, bit 1 the source-B pointer and bit 2 the destination pointer. Each bit leaves the other pointers unchanged, and the new value applies only to later issues.
- R10: An issued instruction with write-enable low leaves the register file unchanged.
- R11: Write-enable and write data are ignored in a cycle without issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is issued this cycle |
| fld_a | input | 8 | Source A operand field |
| fld_b | input | 8 | Source B operand field |
| fld_c | input | 8 | Destination operand field |
| wr_en | input | 1 | Store wr_data at the destination |
| wr_data | input | 32 | Data for the destination register |
| sp_load | input | 1 | Load the window pointer |
| sp_value | input | 7 | New window pointer value |
| ptr_we | input | 3 | Per-port indirect pointer load (bit 0 A, bit 1 B, bit 2 C) |
| ptr_wdata | input | 8 | New indirect pointer value (physical address) |
| opnd_valid | output | 1 | Operands valid |
| opnd_a | output | 32 | Source A operand |
| opnd_b | output | 32 | Source B operand |

## Verification
The bench targets the window sum at its wrap. An adder that carried into the bank bit, or that did not wrap at 128, would read a global register or the wrong local one. It checks that a zero field uses its own port's pointer with no window offset, and it loads the pointers and the window pointer in the same cycle as an issue. A design that used the new value too early would return the wrong register. The bench also sends back-to-back writers and readers of one entry: without bypass the reader gets stale data, and a design that commits writes without issue or with write-enable low would change entries it must leave alone.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   // Where an operand field takes its physical address from
   typedef enum logic [1:0] {
      SRC_GLOBAL   = 2'd0,
      SRC_LOCAL    = 2'd1,
      SRC_INDIRECT = 2'd2
   } src_e;

   localparam int unsigned NUM_PORTS = 3;
   localparam int unsigned PORT_A    = 0;
   localparam int unsigned PORT_B    = 1;
   localparam int unsigned PORT_C    = 2;
   localparam int unsigned NUM_RD    = 2;

endpackage

// File: rtl/regwin_addr_gen.sv
module regwin_addr_gen
   import regwin_pkg::*;
#(
   parameter int unsigned OFF_W = 7
)(
   input  logic [OFF_W:0]   field,
   input  logic [OFF_W-1:0] sp,
   input  logic [OFF_W:0]   ptr,
   output logic [OFF_W:0]   phys
);

   logic [OFF_W-1:0] local_idx;
   logic             is_zero;
   src_e             sel;

   // Dedicated narrow adder: carry out of the offset width is dropped
   assign local_idx = field[OFF_W-1:0] + sp;
   assign is_zero   = (field == '0);

   always_comb begin
      if (is_zero)
         sel = SRC_INDIRECT;
      else if (field[OFF_W])
         sel = SRC_LOCAL;
      else
         sel = SRC_GLOBAL;
   end

   always_comb begin
      case (sel)
         SRC_LOCAL:    phys = {1'b1, local_idx};
         SRC_INDIRECT: phys = ptr;
         default:      phys = {1'b0, field[OFF_W-1:0]};
      endcase
   end

endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile
   import regwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WRITE_LAG = 1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] ra_addr,
   input  logic [ADDR_W-1:0] rb_addr,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] ra_data,
   output logic [DATA_W-1:0] rb_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] rd_addr [NUM_RD];
   logic [DATA_W-1:0] rd_next [NUM_RD];

   logic              cm_en;
   logic [ADDR_W-1:0] cm_addr;
   logic [DATA_W-1:0] cm_data;

   assign rd_addr[0] = ra_addr;
   assign rd_addr[1] = rb_addr;

   generate
      if (WRITE_LAG == 1) begin : g_lagged
         // Write is held one more stage, read path forwards it
         always_ff @(posedge clk) begin
            if (rst)
               cm_en <= 1'b0;
            else
               cm_en <= wr_req;
         end

         always_ff @(posedge clk) begin
            cm_addr <= wr_addr;
            cm_data <= wr_data;
         end

         always_comb begin
            for (int p = 0; p < NUM_RD; p++) begin
               rd_next[p] = mem[rd_addr[p]];
               if (cm_en && (cm_addr == rd_addr[p]))
                  rd_next[p] = cm_data;
            end
         end
      end else begin : g_direct
         // Write commits at the edge that reads the same instruction
         assign cm_en   = wr_req;
         assign cm_addr = wr_addr;
         assign cm_data = wr_data;

         always_comb begin
            for (int p = 0; p < NUM_RD; p++)
               rd_next[p] = mem[rd_addr[p]];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (cm_en)
         mem[cm_addr] <= cm_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         ra_data  <= '0;
         rb_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            ra_data <= rd_next[0];
            rb_data <= rd_next[1];
         end
      end
   end

endmodule

// File: rtl/regwin_operand_unit.sv
module regwin_operand_unit
   import regwin_pkg::*;
#(
   parameter int unsigned OFF_W     = 7,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WRITE_LAG = 1
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 iss_valid,
   input  logic [OFF_W:0]       fld_a,
   input  logic [OFF_W:0]       fld_b,
   input  logic [OFF_W:0]       fld_c,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 sp_load,
   input  logic [OFF_W-1:0]     sp_value,
   input  logic [NUM_PORTS-1:0] ptr_we,
   input  logic [OFF_W:0]       ptr_wdata,
   output logic                 opnd_valid,
   output logic [DATA_W-1:0]    opnd_a,
   output logic [DATA_W-1:0]    opnd_b
);

   localparam int unsigned FLD_W = OFF_W + 1;
   localparam int unsigned PA_W  = OFF_W + 1;

   generate
      if (OFF_W < 2 || OFF_W > 12) begin : g_bad_off
         $error("regwin_operand_unit: OFF_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("regwin_operand_unit: DATA_W must be positive");
      end
      if (WRITE_LAG > 1) begin : g_bad_lag
         $error("regwin_operand_unit: WRITE_LAG must be 0 or 1");
      end
   endgenerate

   logic [OFF_W-1:0] sp_q;
   logic [PA_W-1:0]  ptr_q   [NUM_PORTS];
   logic [FLD_W-1:0] fld     [NUM_PORTS];
   logic [PA_W-1:0]  phys    [NUM_PORTS];
   logic [PA_W-1:0]  s1_addr [NUM_PORTS];
   logic             s1_valid;
   logic             s1_we;
   logic [DATA_W-1:0] s1_wdata;

   assign fld[PORT_A] = fld_a;
   assign fld[PORT_B] = fld_b;
   assign fld[PORT_C] = fld_c;

   // Window pointer
   always_ff @(posedge clk) begin
      if (rst)
         sp_q <= '0;
      else if (sp_load)
         sp_q <= sp_value;
   end

   // Per-port indirect pointers and per-port address generators
   genvar gp;
   generate
      for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
         always_ff @(posedge clk) begin
            if (rst)
               ptr_q[gp] <= '0;
            else if (ptr_we[gp])
               ptr_q[gp] <= ptr_wdata;
         end

         regwin_addr_gen #(
            .OFF_W (OFF_W)
         ) u_ag (
            .field (fld[gp]),
            .sp    (sp_q),
            .ptr   (ptr_q[gp]),
            .phys  (phys[gp])
         );
      end
   endgenerate

   // Address stage
   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_we    <= 1'b0;
      end else begin
         s1_valid <= iss_valid;
         s1_we    <= iss_valid && wr_en;
      end
   end

   always_ff @(posedge clk) begin
      if (iss_valid) begin
         for (int p = 0; p < NUM_PORTS; p++)
            s1_addr[p] <= phys[p];
         s1_wdata <= wr_data;
      end
   end

   regwin_regfile #(
      .ADDR_W    (PA_W),
      .DATA_W    (DATA_W),
      .WRITE_LAG (WRITE_LAG)
   ) u_rf (
      .clk      (clk),
      .rst      (rst),
      .rd_en    (s1_valid),
      .ra_addr  (s1_addr[PORT_A]),
      .rb_addr  (s1_addr[PORT_B]),
      .wr_req   (s1_we),
      .wr_addr  (s1_addr[PORT_C]),
      .wr_data  (s1_wdata),
      .rd_valid (opnd_valid),
      .ra_data  (opnd_a),
      .rb_data  (opnd_b)
   );

endmodule

// File: rtl/regwin_operand_chk.sv
module regwin_operand_chk #(
   parameter int unsigned OFF_W = 7
)(
   input logic             clk,
   input logic             rst,
   input logic             iss_valid,
   input logic [OFF_W:0]   fld_a,
   input logic [OFF_W:0]   fld_b,
   input logic             wr_en,
   input logic             sp_load,
   input logic [OFF_W-1:0] sp_value,
   input logic [2:0]       ptr_we,
   input logic             opnd_valid,
   input logic [OFF_W-1:0] sp_q,
   input logic [OFF_W:0]   ptr_a,
   input logic [OFF_W:0]   s1_addr_a,
   input logic [OFF_W:0]   s1_addr_b,
   input logic             s1_we
);

   logic [OFF_W-1:0] win_sum_a;
   assign win_sum_a = fld_a[OFF_W-1:0] + sp_q;

   // R5
   issue_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      iss_valid |=> ##1 opnd_valid);

   // R5
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !iss_valid |=> ##1 !opnd_valid);

   // R2
   local_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && fld_a[OFF_W]) |=> (s1_addr_a == {1'b1, $past(win_sum_a)}));

   // R3
   global_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && !fld_b[OFF_W] && (fld_b != '0)) |=> (s1_addr_b == $past(fld_b)));

   // R4
   indirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && (fld_a == '0)) |=> (s1_addr_a == $past(ptr_a)));

   // R8
   sp_load_chk: assert property (@(posedge clk) disable iff (rst)
      sp_load |=> (sp_q == $past(sp_value)));

   // R8
   sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !sp_load |=> $stable(sp_q));

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ptr_we[0] |=> $stable(ptr_a));

   // R10
   no_write_chk: assert property (@(posedge clk) disable iff (rst)
      !(iss_valid && wr_en) |=> !s1_we);

endmodule

bind regwin_operand_unit regwin_operand_chk #(
   .OFF_W (OFF_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .iss_valid  (iss_valid),
   .fld_a      (fld_a),
   .fld_b      (fld_b),
   .wr_en      (wr_en),
   .sp_load    (sp_load),
   .sp_value   (sp_value),
   .ptr_we     (ptr_we),
   .opnd_valid (opnd_valid),
   .sp_q       (sp_q),
   .ptr_a      (ptr_q[0]),
   .s1_addr_a  (s1_addr[0]),
   .s1_addr_b  (s1_addr[1]),
   .s1_we      (s1_we)
);

// File: tb/regwin_operand_unit_bench.sv
`timescale 1ns/1ps
module regwin_operand_unit_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        iss_valid;
   logic [7:0]  fld_a, fld_b, fld_c;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        sp_load;
   logic [6:0]  sp_value;
   logic [2:0]  ptr_we;
   logic [7:0]  ptr_wdata;
   logic        opnd_valid;
   logic [31:0] opnd_a, opnd_b;

   always #10 clk = ~clk;

   regwin_operand_unit u_regwin_operand_unit (
      .clk(clk), .rst(rst), .iss_valid(iss_valid),
      .fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c),
      .wr_en(wr_en), .wr_data(wr_data),
      .sp_load(sp_load), .sp_value(sp_value),
      .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
      .opnd_valid(opnd_valid), .opnd_a(opnd_a), .opnd_b(opnd_b)
   );

   typedef struct {
      bit          chk;
      logic [31:0] ea;
      logic [31:0] eb;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   exp_t        mon_e;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;

   logic [31:0] m_rf [256];
   logic [6:0]  m_sp;
   logic [7:0]  m_ptr [3];

   function automatic logic [31:0] gval(int i);
      return 32'h6000_0000 | i;
   endfunction

   function automatic logic [31:0] lval(int i);
      return 32'h9000_0000 | i;
   endfunction

   function automatic logic [7:0] mphys(logic [7:0] f, int p);
      logic [6:0] s;
      if (f == 8'h00) return m_ptr[p];
      s = f[6:0] + m_sp;
      if (f[7]) return {1'b1, s};
      return {1'b0, f[6:0]};
   endfunction

   // Driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic drive(bit iv, logic [7:0] fa, logic [7:0] fb, logic [7:0] fc,
                        bit we, logic [31:0] wd, bit spl, logic [6:0] spv,
                        logic [2:0] pwe, logic [7:0] pwd, bit chk, string tag);
      exp_t e;
      @(negedge clk);
      iss_valid = iv; fld_a = fa; fld_b = fb; fld_c = fc;
      wr_en = we; wr_data = wd; sp_load = spl; sp_value = spv;
      ptr_we = pwe; ptr_wdata = pwd;
      if (iv) begin
         e.chk = chk;
         e.ea  = m_rf[mphys(fa, 0)];
         e.eb  = m_rf[mphys(fb, 1)];
         e.tag = tag;
         sb.push_back(e);
         if (we) m_rf[mphys(fc, 2)] = wd;
      end
      if (spl) m_sp = spv;
      for (int p = 0; p < 3; p++)
         if (pwe[p]) m_ptr[p] = pwd;
   endtask

   task automatic issue(logic [7:0] fa, logic [7:0] fb, logic [7:0] fc,
                        bit we, logic [31:0] wd, string tag);
      drive(1'b1, fa, fb, fc, we, wd, 1'b0, 7'd0, 3'b000, 8'h00, 1'b1, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++)
         drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 32'h0, 1'b0, 7'd0, 3'b000, 8'h00, 1'b0, "");
   endtask

   // Monitor: pops one expected item per valid operand pair
   always @(negedge clk) begin
      if (!rst && opnd_valid && !finished) begin
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5 unexpected valid: actual a=%h b=%h expected no valid", opnd_a, opnd_b);
         end else begin
            mon_e = sb.pop_front();
            if (mon_e.chk) begin
               checks++;
               if (opnd_a !== mon_e.ea || opnd_b !== mon_e.eb) begin
                  errors++;
                  $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h",
                           mon_e.tag, opnd_a, opnd_b, mon_e.ea, mon_e.eb);
               end
            end
         end
      end
   end

   task automatic finish_run();
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      rst = 1'b1; iss_valid = 0; fld_a = 0; fld_b = 0; fld_c = 0;
      wr_en = 0; wr_data = 0; sp_load = 0; sp_value = 0; ptr_we = 0; ptr_wdata = 0;
      m_sp = 0;
      for (int p = 0; p < 3; p++) m_ptr[p] = 8'h00;
      for (int i = 0; i < 256; i++) m_rf[i] = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (opnd_valid !== 1'b0 || opnd_a !== 32'h0 || opnd_b !== 32'h0) begin
         errors++;
         $display("FAIL R1 reset outputs: actual v=%b a=%h b=%h expected 0 0 0", opnd_valid, opnd_a, opnd_b);
      end

      // Fill: global 0 via destination pointer at its reset value (R1, R4)
      drive(1'b1, 8'h01, 8'h01, 8'h00, 1'b1, gval(0), 1'b0, 7'd0, 3'b000, 8'h00, 1'b0, "fill");
      for (int i = 1; i < 128; i++)
         drive(1'b1, 8'h01, 8'h01, 8'(i), 1'b1, gval(i), 1'b0, 7'd0, 3'b000, 8'h00, 1'b0, "fill");
      for (int i = 0; i < 128; i++)
         drive(1'b1, 8'h01, 8'h01, 8'h80 | 8'(i), 1'b1, lval(i), 1'b0, 7'd0, 3'b000, 8'h00, 1'b0, "fill");

      issue(8'h00, 8'h00, 8'h01, 1'b0, 32'h0, "R1 pointers reset to address 0");
      issue(8'h85, 8'hFF, 8'h01, 1'b0, 32'h0, "R1 window pointer reset to 0");

      issue(8'h05, 8'h7F, 8'h01, 1'b0, 32'h0, "R3 global direct");
      issue(8'h40, 8'h01, 8'h01, 1'b0, 32'h0, "R3 global mid");

      drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 32'h0, 1'b1, 7'd10, 3'b000, 8'h00, 1'b0, "");
      issue(8'h83, 8'hFF, 8'h01, 1'b0, 32'h0, "R2 local offset and wrap");
      issue(8'h80, 8'hF6, 8'h01, 1'b0, 32'h0, "R2 local wrap to 0");

      drive(1'b1, 8'h81, 8'h81, 8'h01, 1'b0, 32'h0, 1'b1, 7'd50, 3'b000, 8'h00, 1'b1, "R8 same-cycle load uses old pointer");
      issue(8'h81, 8'h8F, 8'h01, 1'b0, 32'h0, "R8 later issue uses new pointer");

      drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 32'h0, 1'b0, 7'd0, 3'b001, 8'h85, 1'b0, "");
      drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 32'h0, 1'b0, 7'd0, 3'b010, 8'h10, 1'b0, "");
      issue(8'h00, 8'h00, 8'h01, 1'b0, 32'h0, "R4 indirect per port, no window offset");
      drive(1'b1, 8'h00, 8'h00, 8'h01, 1'b0, 32'h0, 1'b0, 7'd0, 3'b001, 8'h22, 1'b1, "R9 same-cycle pointer load uses old value");
      issue(8'h00, 8'h00, 8'h01, 1'b0, 32'h0, "R9 only pointer A changed");

      issue(8'h30, 8'h31, 8'h30, 1'b1, 32'hDEAD_0001, "R6 own read sees old value");
      issue(8'h30, 8'h01, 8'h01, 1'b0, 32'h0, "R7 bypass to next issue");
      issue(8'h30, 8'h30, 8'h01, 1'b0, 32'h0, "R7 stored value later");
      issue(8'h82, 8'h82, 8'h82, 1'b1, 32'hBEEF_0002, "R6 local own read old");
      issue(8'h82, 8'h05, 8'h01, 1'b0, 32'h0, "R7 local bypass");

      drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 32'h0, 1'b0, 7'd0, 3'b100, 8'h93, 1'b0, "");
      issue(8'h01, 8'h01, 8'h00, 1'b1, 32'hC0DE_0003, "R4 destination pointer write");
      issue(8'hE1, 8'h13, 8'h01, 1'b0, 32'h0, "R4 destination pointer hit local bank");

      issue(8'h02, 8'h02, 8'h40, 1'b1, 32'hA1A1_0001, "R6 first writer");
      issue(8'h40, 8'h40, 8'h40, 1'b1, 32'hA2A2_0002, "R7 back-to-back writer reads bypass");
      issue(8'h40, 8'h03, 8'h01, 1'b0, 32'h0, "R7 second write wins");

      issue(8'h31, 8'h31, 8'h31, 1'b0, 32'hFFFF_FFFF, "R10 disabled write");
      issue(8'h31, 8'h31, 8'h01, 1'b0, 32'h0, "R10 entry unchanged");

      drive(1'b0, 8'h00, 8'h00, 8'h32, 1'b1, 32'h1234_5678, 1'b0, 7'd0, 3'b000, 8'h00, 1'b0, "");
      idle(2);
      issue(8'h32, 8'h32, 8'h01, 1'b0, 32'h0, "R11 write without issue ignored");

      for (int i = 0; i < 16; i++)
         issue(8'h80 | 8'(i), 8'(i + 1), 8'h80 | 8'(i + 1), 1'b1, 32'h5500_0000 | i,
               "R2 R7 streamed local writes");

      idle(4);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R5 missing operands: actual %0d pending expected 0", sb.size());
      end
      finish_run();
   end

endmodule